// File: doc/BRIEF.md
# Band-and-strip scanout address generator

This block turns raster timing into per-pixel fetch coordinates for a display whose screen is assembled from many bitmaps. The screen is cut vertically into bands of scanlines. Each band selects one strip list, and the strip list cuts every scanline of that band horizontally into strips. Every strip points at its own bitmap, with its own start word address, row stride in words and pixel depth. For each active pixel the block reports the 16-bit memory word that holds the pixel, the bit position of the pixel inside that word and the depth. Fetching the word and extracting the pixel are done downstream.

Software fills a shadow copy of the band table and the strip lists through two write ports. The copy the walkers read is replaced by the shadow copy only on the frame strobe, so a frame is always drawn from one consistent set of descriptors. A single band covering the whole screen, using one strip as wide as the line, gives an ordinary full-screen bitmap.

Top module: `wl_scanout`

## Requirements
- R1: Out of reset `o_valid` is low and the active tables are empty, so every pixel of a frame drawn before any descriptor is committed comes out blank.
- R2: A cycle with `pix_en_i` high and both `vsync_i` and `line_start_i` low produces exactly one output with `o_valid` high in the following cycle. Every other cycle produces `o_valid` low on the next cycle.
- R3: Scanlines are counted from 0 at the first `line_start_i` after `vsync_i`. Line n falls in the first band whose running total of line counts exceeds n, and the row index is n minus the lines of the earlier bands. A band with a line count of zero ends the band table.
- R4: Pixels are counted from 0 at each `line_start_i`, advancing only on `pix_en_i`. Pixel x falls in the first strip of the band's list whose running total of widths exceeds x. A list holds up to 16 strips, and a strip of width zero ends the list.
- R5: For a covered pixel, `o_addr` = start + row × stride + floor(xoff × depth / 16), modulo 2^20, where xoff is the pixel's offset within its strip.
- R6: Pixels are packed from the most significant end of the word. `o_bit` is the index of the pixel field's least significant bit, which is 16 − depth − ((xoff × depth) mod 16). The first pixel of a word at depth 1 is at bit 15, and at depth 8 it is at bit 8.
- R7: Depth codes 1, 2, 4 and 8 are used as given. Every other code (0, 3, 5–7, 9–15) acts as 8 in the address and bit arithmetic and is reported as 8 on `o_depth`.
- R8: A pixel beyond the last strip of its line, or on a line beyond the last band, gives `o_blank` high with `o_addr`, `o_bit` and `o_depth` at zero.
- R9: Descriptor writes go into the shadow tables and do not affect any output until the next `vsync_i`. On that strobe the whole shadow set becomes active.
- R10: One band with a line count equal to the frame height and one strip as wide as the line map the whole screen onto one bitmap.
- R11: `vsync_i` restarts at band 0, row 0, and it overrides `line_start_i` and `pix_en_i`. `line_start_i` restarts at strip 0, offset 0, even when the previous line was cut short, and it overrides `pix_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Frame strobe: commits the shadow tables and restarts the frame |
| line_start_i | input | 1 | Scanline strobe |
| pix_en_i | input | 1 | Active pixel this cycle |
| band_we_i | input | 1 | Write one band entry into the shadow table |
| band_idx_i | input | 2 | Band entry index |
| band_lines_i | input | 8 | Scanlines covered by the band (0 ends the table) |
| band_list_i | input | 2 | Strip list chosen by the band |
| strip_we_i | input | 1 | Write one strip entry into the shadow lists |
| strip_list_i | input | 2 | Strip list being written |
| strip_idx_i | input | 4 | Strip index inside the list |
| strip_width_i | input | 10 | Pixels covered by the strip (0 ends the list) |
| strip_start_i | input | 20 | Bitmap start word address |
| strip_stride_i | input | 12 | Words between bitmap rows |
| strip_depth_i | input | 4 | Bits per pixel code |
| o_valid | output | 1 | Output describes a pixel |
| o_blank | output | 1 | Pixel is not covered by any strip |
| o_addr | output | 20 | Word address holding the pixel |
| o_bit | output | 4 | Least significant bit index of the pixel field |
| o_depth | output | 4 | Effective pixel depth |

## Verification
The hardest state to reach is the end of a list: a band whose list holds all sixteen strips, where the strip index runs past the last entry while the line still has pixels left. A band with zero lines placed in the middle of the table is almost as hard to reach. Directed frames build both cases: one list with sixteen narrow strips that together fall short of the line, and a band table with an empty middle entry. Frames with random bands, strip lists, depth codes, truncated lines and idle bubbles between pixels are then checked against a model that finds the band and strip for each pixel by running sums, not by counters. Writes made in the middle of a frame and a second frame strobe in the middle of a frame cover the commit and restart rules.

// File: rtl/wl_pkg.sv
package wl_pkg;

  localparam int ADDR_W    = 20;
  localparam int STRIDE_W  = 12;
  localparam int LINES_W   = 8;
  localparam int PIX_W     = 10;
  localparam int DEPTH_W   = 4;
  localparam int BIT_W     = 4;
  localparam int WORD_BITS = 16;

  typedef struct packed {
    logic [PIX_W-1:0]    width;
    logic [ADDR_W-1:0]   start;
    logic [STRIDE_W-1:0] stride;
    logic [DEPTH_W-1:0]  depth;
  } strip_t;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Accepted depths pass through, every other code becomes 8.
  function automatic logic [DEPTH_W-1:0] norm_depth(input logic [DEPTH_W-1:0] d);
    case (d)
      4'd1, 4'd2, 4'd4: return d;
      default:          return 4'd8;
    endcase
  endfunction

  function automatic logic [1:0] depth_shift(input logic [DEPTH_W-1:0] d);
    case (d)
      4'd1:    return 2'd0;
      4'd2:    return 2'd1;
      4'd4:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/wl_desc_store.sv
module wl_desc_store
  import wl_pkg::*;
#(
  parameter int NBANDS  = 4,
  parameter int NLISTS  = 4,
  parameter int NSTRIPS = 16,
  localparam int BIDX_W = idx_w(NBANDS),
  localparam int BCNT_W = $clog2(NBANDS + 1),
  localparam int LSEL_W = idx_w(NLISTS),
  localparam int SIDX_W = idx_w(NSTRIPS),
  localparam int SCNT_W = $clog2(NSTRIPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic               band_we_i,
  input  logic [BIDX_W-1:0]  band_idx_i,
  input  logic [LINES_W-1:0] band_lines_i,
  input  logic [LSEL_W-1:0]  band_list_i,
  input  logic               strip_we_i,
  input  logic [LSEL_W-1:0]  strip_list_i,
  input  logic [SIDX_W-1:0]  strip_idx_i,
  input  strip_t             strip_i,
  input  logic [BCNT_W-1:0]  band_rd_i,
  input  logic [SCNT_W-1:0]  strip_rd_i,
  output logic [LINES_W-1:0] lines_o,
  output strip_t             strip_o
);

  logic [LINES_W-1:0] shd_lines_q [NBANDS];
  logic [LINES_W-1:0] act_lines_q [NBANDS];
  logic [LSEL_W-1:0]  shd_list_q  [NBANDS];
  logic [LSEL_W-1:0]  act_list_q  [NBANDS];
  strip_t             shd_strip_q [NLISTS][NSTRIPS];
  strip_t             act_strip_q [NLISTS][NSTRIPS];

  // Shadow side: written at any time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANDS; b++) begin
        shd_lines_q[b] <= '0;
        shd_list_q[b]  <= '0;
      end
      for (int l = 0; l < NLISTS; l++)
        for (int s = 0; s < NSTRIPS; s++)
          shd_strip_q[l][s] <= '0;
    end else begin
      if (band_we_i) begin
        shd_lines_q[band_idx_i] <= band_lines_i;
        shd_list_q[band_idx_i]  <= band_list_i;
      end
      if (strip_we_i)
        shd_strip_q[strip_list_i][strip_idx_i] <= strip_i;
    end
  end

  // Active side: replaced as a whole on the frame strobe only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANDS; b++) begin
        act_lines_q[b] <= '0;
        act_list_q[b]  <= '0;
      end
      for (int l = 0; l < NLISTS; l++)
        for (int s = 0; s < NSTRIPS; s++)
          act_strip_q[l][s] <= '0;
    end else if (commit_i) begin
      act_lines_q <= shd_lines_q;
      act_list_q  <= shd_list_q;
      act_strip_q <= shd_strip_q;
    end
  end

  logic              band_in, strip_in;
  logic [LSEL_W-1:0] list_sel;

  always_comb begin
    band_in  = band_rd_i < BCNT_W'(NBANDS);
    strip_in = strip_rd_i < SCNT_W'(NSTRIPS);
    lines_o  = band_in ? act_lines_q[band_rd_i[BIDX_W-1:0]] : '0;
    list_sel = band_in ? act_list_q[band_rd_i[BIDX_W-1:0]]  : '0;
    strip_o  = strip_in ? act_strip_q[list_sel][strip_rd_i[SIDX_W-1:0]] : '0;
  end

  // R9: the active table moves only on the frame strobe
  a_r9_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(act_lines_q[0]) && $stable(act_strip_q[0][0]));
  a_r9_active_take: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> act_lines_q[0] == $past(shd_lines_q[0]));

endmodule

// File: rtl/wl_band_walker.sv
module wl_band_walker
  import wl_pkg::*;
#(
  parameter int NBANDS = 4,
  localparam int BCNT_W = $clog2(NBANDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync_i,
  input  logic               line_start_i,
  input  logic [LINES_W-1:0] lines_i,
  output logic [BCNT_W-1:0]  band_o,
  output logic [LINES_W-1:0] row_o,
  output logic               band_ok_o
);

  logic [BCNT_W-1:0]  band_q, band_d;
  logic [LINES_W-1:0] row_q, row_d;
  logic               first_q, first_d;
  logic               band_ok;

  assign band_ok = (band_q < BCNT_W'(NBANDS)) && (lines_i != '0);

  always_comb begin
    band_d  = band_q;
    row_d   = row_q;
    first_d = first_q;
    if (vsync_i) begin
      band_d  = '0;
      row_d   = '0;
      first_d = 1'b1;
    end else if (line_start_i) begin
      if (first_q) begin
        first_d = 1'b0;
      end else if (band_ok) begin
        if ({1'b0, row_q} + 1'b1 >= {1'b0, lines_i}) begin
          band_d = band_q + 1'b1;
          row_d  = '0;
        end else begin
          row_d  = row_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q  <= '0;
      row_q   <= '0;
      first_q <= 1'b1;
    end else begin
      band_q  <= band_d;
      row_q   <= row_d;
      first_q <= first_d;
    end
  end

  assign band_o    = band_q;
  assign row_o     = row_q;
  assign band_ok_o = band_ok;

  // R11: frame strobe returns to the top of the band table
  a_r11_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |=> (band_q == '0) && (row_q == '0));
  // R3: row index stays inside the band it belongs to
  a_r3_row_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    band_ok |-> row_q < lines_i);
  // R3: a closed table stays closed until the next frame
  a_r3_table_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!band_ok && !vsync_i) |=> $stable(band_q));

endmodule

// File: rtl/wl_strip_walker.sv
module wl_strip_walker
  import wl_pkg::*;
#(
  parameter int NSTRIPS = 16,
  localparam int SCNT_W = $clog2(NSTRIPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              step_i,
  input  logic              band_ok_i,
  input  logic [PIX_W-1:0]  width_i,
  output logic [SCNT_W-1:0] sidx_o,
  output logic [PIX_W-1:0]  xoff_o,
  output logic              strip_ok_o
);

  logic [SCNT_W-1:0] sidx_q, sidx_d;
  logic [PIX_W-1:0]  xoff_q, xoff_d;
  logic              strip_ok;

  assign strip_ok = band_ok_i && (sidx_q < SCNT_W'(NSTRIPS)) && (width_i != '0);

  always_comb begin
    sidx_d = sidx_q;
    xoff_d = xoff_q;
    if (restart_i) begin
      sidx_d = '0;
      xoff_d = '0;
    end else if (step_i && strip_ok) begin
      if ({1'b0, xoff_q} + 1'b1 >= {1'b0, width_i}) begin
        sidx_d = sidx_q + 1'b1;
        xoff_d = '0;
      end else begin
        xoff_d = xoff_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sidx_q <= '0;
      xoff_q <= '0;
    end else begin
      sidx_q <= sidx_d;
      xoff_q <= xoff_d;
    end
  end

  assign sidx_o     = sidx_q;
  assign xoff_o     = xoff_q;
  assign strip_ok_o = strip_ok;

  // R4: never walks past one entry beyond the list
  a_r4_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sidx_q <= SCNT_W'(NSTRIPS));
  // R4: offset stays inside the current strip
  a_r4_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
    strip_ok |-> xoff_q < width_i);
  // R11: line strobe restarts the strip walk
  a_r11_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (sidx_q == '0) && (xoff_q == '0));

endmodule

// File: rtl/wl_scanout.sv
module wl_scanout
  import wl_pkg::*;
#(
  parameter int NBANDS  = 4,
  parameter int NLISTS  = 4,
  parameter int NSTRIPS = 16,
  localparam int BIDX_W = idx_w(NBANDS),
  localparam int BCNT_W = $clog2(NBANDS + 1),
  localparam int LSEL_W = idx_w(NLISTS),
  localparam int SIDX_W = idx_w(NSTRIPS),
  localparam int SCNT_W = $clog2(NSTRIPS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vsync_i,
  input  logic                line_start_i,
  input  logic                pix_en_i,
  input  logic                band_we_i,
  input  logic [BIDX_W-1:0]   band_idx_i,
  input  logic [LINES_W-1:0]  band_lines_i,
  input  logic [LSEL_W-1:0]   band_list_i,
  input  logic                strip_we_i,
  input  logic [LSEL_W-1:0]   strip_list_i,
  input  logic [SIDX_W-1:0]   strip_idx_i,
  input  logic [PIX_W-1:0]    strip_width_i,
  input  logic [ADDR_W-1:0]   strip_start_i,
  input  logic [STRIDE_W-1:0] strip_stride_i,
  input  logic [DEPTH_W-1:0]  strip_depth_i,
  output logic                o_valid,
  output logic                o_blank,
  output logic [ADDR_W-1:0]   o_addr,
  output logic [BIT_W-1:0]    o_bit,
  output logic [DEPTH_W-1:0]  o_depth
);

  strip_t             wr_strip, cur_strip;
  logic [LINES_W-1:0] cur_lines, row;
  logic [BCNT_W-1:0]  band;
  logic [SCNT_W-1:0]  sidx;
  logic [PIX_W-1:0]   xoff;
  logic               band_ok, strip_ok, line_restart, pix_go;

  assign wr_strip     = '{width: strip_width_i, start: strip_start_i,
                          stride: strip_stride_i, depth: strip_depth_i};
  assign line_restart = vsync_i || line_start_i;
  assign pix_go       = pix_en_i && !line_restart;

  wl_desc_store #(.NBANDS(NBANDS), .NLISTS(NLISTS), .NSTRIPS(NSTRIPS)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_i     (vsync_i),
    .band_we_i    (band_we_i),
    .band_idx_i   (band_idx_i),
    .band_lines_i (band_lines_i),
    .band_list_i  (band_list_i),
    .strip_we_i   (strip_we_i),
    .strip_list_i (strip_list_i),
    .strip_idx_i  (strip_idx_i),
    .strip_i      (wr_strip),
    .band_rd_i    (band),
    .strip_rd_i   (sidx),
    .lines_o      (cur_lines),
    .strip_o      (cur_strip)
  );

  wl_band_walker #(.NBANDS(NBANDS)) u_band (
    .clk          (clk),
    .rst_n        (rst_n),
    .vsync_i      (vsync_i),
    .line_start_i (line_start_i),
    .lines_i      (cur_lines),
    .band_o       (band),
    .row_o        (row),
    .band_ok_o    (band_ok)
  );

  wl_strip_walker #(.NSTRIPS(NSTRIPS)) u_strip (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (line_restart),
    .step_i     (pix_go),
    .band_ok_i  (band_ok),
    .width_i    (cur_strip.width),
    .sidx_o     (sidx),
    .xoff_o     (xoff),
    .strip_ok_o (strip_ok)
  );

  // Address arithmetic for the current pixel.
  logic [DEPTH_W-1:0] eff_depth;
  logic [PIX_W+2:0]   bit_pos;
  logic [4:0]         lsb_pos;
  logic [ADDR_W-1:0]  pix_addr;

  always_comb begin
    eff_depth = norm_depth(cur_strip.depth);
    bit_pos   = {3'b000, xoff} << depth_shift(cur_strip.depth);
    lsb_pos   = 5'(WORD_BITS) - {1'b0, eff_depth} - {1'b0, bit_pos[3:0]};
    pix_addr  = cur_strip.start
              + ADDR_W'(row) * ADDR_W'(cur_strip.stride)
              + ADDR_W'(bit_pos[PIX_W+2:4]);
  end

  logic               valid_d, blank_d;
  logic [ADDR_W-1:0]  addr_d;
  logic [BIT_W-1:0]   bit_d;
  logic [DEPTH_W-1:0] depth_d;

  always_comb begin
    valid_d = pix_go;
    blank_d = pix_go && !strip_ok;
    addr_d  = o_addr;
    bit_d   = o_bit;
    depth_d = o_depth;
    if (pix_go) begin
      addr_d  = strip_ok ? pix_addr       : '0;
      bit_d   = strip_ok ? lsb_pos[3:0]   : '0;
      depth_d = strip_ok ? eff_depth      : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_blank <= 1'b0;
      o_addr  <= '0;
      o_bit   <= '0;
      o_depth <= '0;
    end else begin
      o_valid <= valid_d;
      o_blank <= blank_d;
      o_addr  <= addr_d;
      o_bit   <= bit_d;
      o_depth <= depth_d;
    end
  end

  // R2: one output per accepted pixel, in the next cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en_i && !vsync_i && !line_start_i) |=> o_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_en_i && !vsync_i && !line_start_i) |=> !o_valid);
  // R8: blank pixels carry zero coordinates
  a_r8_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_blank) |-> (o_addr == '0) && (o_bit == '0) && (o_depth == '0));
  // R7: reported depth is one of the accepted values
  a_r7_depth_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_blank) |-> $onehot0(o_depth) && (o_depth != '0));
  // R6: pixel field lies inside the word and on a depth boundary
  a_r6_field_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_blank) |-> ({1'b0, o_bit} + {1'b0, o_depth} <= 5'd16)
                              && ((o_bit & (o_depth - 4'd1)) == '0));

endmodule

// File: tb/tb_wl_scanout.sv
module tb_wl_scanout;
  import wl_pkg::*;

  localparam int NB = 4;
  localparam int NL = 4;
  localparam int NS = 16;
  localparam int LW = 40;
  localparam int NLN = 12;
  localparam int AMASK = (1 << ADDR_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync_i = 1'b0, line_start_i = 1'b0, pix_en_i = 1'b0;
  logic band_we_i = 1'b0, strip_we_i = 1'b0;
  logic [1:0] band_idx_i = '0, band_list_i = '0, strip_list_i = '0;
  logic [LINES_W-1:0] band_lines_i = '0;
  logic [3:0] strip_idx_i = '0, strip_depth_i = '0;
  logic [PIX_W-1:0] strip_width_i = '0;
  logic [ADDR_W-1:0] strip_start_i = '0;
  logic [STRIDE_W-1:0] strip_stride_i = '0;
  logic o_valid, o_blank;
  logic [ADDR_W-1:0] o_addr;
  logic [BIT_W-1:0] o_bit;
  logic [DEPTH_W-1:0] o_depth;

  wl_scanout dut (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .line_start_i(line_start_i),
    .pix_en_i(pix_en_i), .band_we_i(band_we_i), .band_idx_i(band_idx_i),
    .band_lines_i(band_lines_i), .band_list_i(band_list_i),
    .strip_we_i(strip_we_i), .strip_list_i(strip_list_i), .strip_idx_i(strip_idx_i),
    .strip_width_i(strip_width_i), .strip_start_i(strip_start_i),
    .strip_stride_i(strip_stride_i), .strip_depth_i(strip_depth_i),
    .o_valid(o_valid), .o_blank(o_blank), .o_addr(o_addr), .o_bit(o_bit),
    .o_depth(o_depth)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  string cur_tag = "R1";

  // Shadow and committed copies kept by the bench.
  int s_lines [NB], s_list [NB], m_lines [NB], m_list [NB];
  int s_w [NL][NS], s_st [NL][NS], s_sd [NL][NS], s_dp [NL][NS];
  int m_w [NL][NS], m_st [NL][NS], m_sd [NL][NS], m_dp [NL][NS];

  bit exp_pend = 0;
  int exp_y = 0, exp_x = 0, cur_y = -1;

  task automatic chk(string req, string what, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s (%s) %s: got %0h expected %0h", req, cur_tag, what, got, exp);
    end
  endtask

  function automatic int eff_d(int code);
    return (code == 1 || code == 2 || code == 4) ? code : 8;
  endfunction

  // Band and strip located by running sums over the committed tables.
  function automatic void model(int y, int x, output bit blk, output int a,
                                output int b, output int d);
    int cum, band, row, lst, s, xo, bits;
    blk = 1; a = 0; b = 0; d = 0;
    band = -1; row = 0; cum = 0;
    for (int i = 0; i < NB; i++) begin
      if (m_lines[i] == 0) break;
      if (y < cum + m_lines[i]) begin band = i; row = y - cum; break; end
      cum += m_lines[i];
    end
    if (band < 0 || y < 0) return;
    lst = m_list[band];
    s = -1; xo = 0; cum = 0;
    for (int i = 0; i < NS; i++) begin
      if (m_w[lst][i] == 0) break;
      if (x < cum + m_w[lst][i]) begin s = i; xo = x - cum; break; end
      cum += m_w[lst][i];
    end
    if (s < 0) return;
    blk = 0;
    d = eff_d(m_dp[lst][s]);
    bits = xo * d;
    a = (m_st[lst][s] + row * m_sd[lst][s] + bits / 16) & AMASK;
    b = 16 - d - (bits % 16);
  endfunction

  task automatic tick();
    bit eb; int ea, ebit, ed;
    @(negedge clk);
    if (exp_pend) begin
      model(exp_y, exp_x, eb, ea, ebit, ed);
      chk("R2", "valid", int'(o_valid), 1);
      chk(eb ? "R8" : "R4", "blank", int'(o_blank), int'(eb));
      if (!eb) begin
        chk("R5", "addr", int'(o_addr), ea);
        chk("R6", "bit", int'(o_bit), ebit);
        chk("R7", "depth", int'(o_depth), ed);
      end
    end else begin
      chk("R2", "idle valid", int'(o_valid), 0);
    end
    exp_pend = 0;
    vsync_i = 0; line_start_i = 0; pix_en_i = 0; band_we_i = 0; strip_we_i = 0;
  endtask

  task automatic do_vsync();
    tick();
    vsync_i = 1;
    m_lines = s_lines; m_list = s_list;
    m_w = s_w; m_st = s_st; m_sd = s_sd; m_dp = s_dp;
    cur_y = -1;
  endtask

  task automatic do_line();
    tick();
    line_start_i = 1;
    cur_y++;
  endtask

  task automatic do_pix(int x);
    tick();
    pix_en_i = 1;
    exp_pend = 1; exp_y = cur_y; exp_x = x;
  endtask

  task automatic wr_band(int i, int lines, int lst);
    tick();
    band_we_i = 1; band_idx_i = 2'(i); band_lines_i = LINES_W'(lines); band_list_i = 2'(lst);
    s_lines[i] = lines; s_list[i] = lst;
  endtask

  task automatic wr_strip(int l, int i, int w, int st, int sd, int dp);
    tick();
    strip_we_i = 1; strip_list_i = 2'(l); strip_idx_i = 4'(i);
    strip_width_i = PIX_W'(w); strip_start_i = ADDR_W'(st);
    strip_stride_i = STRIDE_W'(sd); strip_depth_i = 4'(dp);
    s_w[l][i] = w; s_st[l][i] = st & AMASK; s_sd[l][i] = sd & 32'hFFF; s_dp[l][i] = dp & 15;
  endtask

  task automatic clear_all();
    for (int b = 0; b < NB; b++) wr_band(b, 0, 0);
    for (int l = 0; l < NL; l++)
      for (int i = 0; i < NS; i++) wr_strip(l, i, 0, 0, 0, 0);
  endtask

  // One frame; npix < 0 picks a random line length; wr_line >= 0 writes mid-frame.
  task automatic frame(int nlines, int npix, int bubble, int wr_line);
    int n;
    do_vsync();
    for (int y = 0; y < nlines; y++) begin
      do_line();
      tick();
      n = (npix < 0) ? 1 + int'($urandom % LW) : npix;
      for (int x = 0; x < n; x++) begin
        if (int'($urandom % 100) < bubble) tick();
        do_pix(x);
      end
      if (y == wr_line) wr_strip(0, 0, LW, 'h7000, 20, 2);
    end
    tick(); tick();
  endtask

  task automatic random_cfg();
    int n;
    for (int b = 0; b < NB; b++)
      wr_band(b, (($urandom % 10) == 0) ? 0 : 1 + int'($urandom % 5), int'($urandom % NL));
    for (int l = 0; l < NL; l++) begin
      n = 1 + int'($urandom % NS);
      for (int i = 0; i < NS; i++)
        if (i < n) wr_strip(l, i, 1 + int'($urandom % 6), int'($urandom), int'($urandom), int'($urandom % 16));
        else       wr_strip(l, i, 0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int b = 0; b < NB; b++) begin s_lines[b] = 0; s_list[b] = 0; end
    for (int l = 0; l < NL; l++)
      for (int i = 0; i < NS; i++) begin
        s_w[l][i] = 0; s_st[l][i] = 0; s_sd[l][i] = 0; s_dp[l][i] = 0;
      end
    m_lines = s_lines; m_list = s_list; m_w = s_w; m_st = s_st; m_sd = s_sd; m_dp = s_dp;
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk("R1", "reset valid", int'(o_valid), 0);
    rst_n = 1;
    // R1: nothing committed yet, every pixel blank
    frame(2, LW, 0, -1);

    // R10: one band, one strip, whole screen
    cur_tag = "R10";
    wr_band(0, NLN, 0);
    wr_strip(0, 0, LW, 'h100, 20, 1);
    frame(NLN, LW, 0, -1);

    // R9: a mid-frame write is held back until the next frame strobe
    cur_tag = "R9";
    frame(NLN, LW, 10, 3);
    frame(2, LW, 0, -1);

    // R4: sixteen strips that fall short of the line
    cur_tag = "R4";
    clear_all();
    wr_band(0, 3, 2);
    for (int i = 0; i < NS; i++) wr_strip(2, i, 2, 'h2000 + 64 * i, 7, (i % 4 == 0) ? 1 : i);
    frame(4, LW, 0, -1);

    // R3: an empty band in the middle closes the table
    cur_tag = "R3";
    wr_band(0, 2, 1); wr_band(1, 0, 3); wr_band(2, 3, 3);
    wr_strip(1, 0, 9, 'h300, 5, 4); wr_strip(1, 1, 11, 'h900, 3, 2);
    frame(5, LW, 0, -1);
    wr_band(1, 2, 3); wr_band(3, 4, 2);
    wr_strip(3, 0, 20, 'hFFFF0, 'hFFF, 8);   // R5: address wraps
    frame(NLN, LW, 5, -1);

    // R11: frame strobe and line strobe in mid-walk
    cur_tag = "R11";
    do_vsync(); do_line(); tick();
    for (int x = 0; x < 13; x++) do_pix(x);
    frame(4, -1, 20, -1);

    // R7: random tables, depth codes and line lengths
    for (int f = 0; f < 10; f++) begin
      cur_tag = "R7";
      random_cfg();
      frame(NLN, (f % 2 == 0) ? LW : -1, 15, -1);
    end
    tick();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule